// File: doc/BRIEF.md
# Multi-Address Target Memory Pointer Unit

This block sits beside the byte engine of a serial-bus target that answers to four addresses. It records which of the four addresses the controller last selected, and it keeps two pointers into the memory seen through that address. The current pointer follows every byte moved in either direction. The read pointer follows only the bytes sent back to the controller. Each address has a base page and a rollover setting. The active index picks which of these apply and steers the transmit page.

Each address can be set to take the first byte written after its match as a memory address. That byte is loaded into the current pointer instead of being counted as data. Software sees three 16-bit registers through a simple write strobe and a combinational read port. The registers are the select register, the current pointer and the read pointer. Software writes win over hardware updates made in the same cycle.

Top module: `tgt_ptr_unit`

## Requirements
- R1: After reset, the select register, both pointers and the captured byte are zero. `tx_page` and `mem_loc` are therefore zero as well.
- R2: A pulse on `match_evt` does three things:
  - it loads the select register's low nibble with `{2'b00, match_idx}`;
  - it marks the unit as addressed;
  - it loads the current pointer's page bits with the base page of that index. The base page for index i is `base_page[3*i+2:3*i]`.
- R3: When the capture enable for the matched index is set in select register bit `4+index`, the first byte after the match is handled specially if it is a write (`dir_rd`=0). It loads the current pointer with `{base page of the active index, rx_byte}` and is remembered as the captured byte. After that first byte, later bytes are counted normally.
- R4: Software can write select register bits 7:0 (register address 0). `tx_page` always equals select bits 3:0. A written value persists until the next match event.
- R5: Both pointer registers keep a 3-bit page in bits 10:8 and an 8-bit address in bits 7:0. Register address 1 is the current pointer and address 2 is the read pointer. Bits 15:11 of every register, and the whole of register address 3, read as zero. `mem_loc` equals the current pointer.
- R6: Each byte moved while addressed advances the current pointer's address field. At FFh it wraps to 00h in the same page when `roll_en` of the active index (select bits 1:0) is 1. Otherwise it stays at FFh.
- R7: Each byte with `dir_rd`=1 while addressed advances the read pointer's address field, using the same rollover rule.
- R8: Writing 0000h to the read pointer loads it with `{base page of the active index, captured byte}`. Any other write loads bits 10:0 as written.
- R9: A software write to a register takes priority over any hardware update of that register in the same cycle.
- R10: While not addressed, byte strobes leave both pointers unchanged. The unit is not addressed after reset, or after `bus_stop` with no new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_evt | input | 1 | One-cycle address match pulse |
| match_idx | input | 2 | Index of the matched address |
| bus_stop | input | 1 | End of transaction; clears the addressed state |
| byte_done | input | 1 | One-cycle strobe per byte moved |
| dir_rd | input | 1 | 1 when the byte went to the controller |
| rx_byte | input | 8 | Byte received from the controller |
| base_page | input | 12 | Four 3-bit base pages, index 0 in the low bits |
| roll_en | input | 4 | Per-index rollover enable |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 2 | Software register address |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Read data of the addressed register |
| tx_page | output | 4 | Transmit page select (active index field) |
| mem_loc | output | 11 | Current pointer (page and address) |

## Verification
All state is registered, so every result of a stimulus applied before a rising edge is visible on `tx_page`, `mem_loc` and `sw_rdata` after that edge. The bench changes inputs only at falling edges, advances its own model at the rising edge, and compares at the next falling edge. That means each check lands exactly one cycle after its cause. `sw_rdata` is combinational from the registers, so it is compared for whatever address is driven in the same half cycle. Directed sequences cover saturation, wrap, capture and the read-pointer reload. A seeded random phase biases pointer writes towards FFh so that the boundaries recur.

// File: rtl/tgt_ptr_unit.sv
module tgt_ptr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        match_evt,
  input  logic [1:0]  match_idx,
  input  logic        bus_stop,
  input  logic        byte_done,
  input  logic        dir_rd,
  input  logic [7:0]  rx_byte,
  input  logic [11:0] base_page,
  input  logic [3:0]  roll_en,
  input  logic        sw_wr,
  input  logic [1:0]  sw_addr,
  input  logic [15:0] sw_wdata,
  output logic [15:0] sw_rdata,
  output logic [3:0]  tx_page,
  output logic [10:0] mem_loc
);
  localparam int NTGT = 4;
  localparam int PW   = 3;
  localparam int AW   = 8;

  logic [7:0]        sel_q;
  logic [PW+AW-1:0]  cur_q, rd_q;
  logic [AW-1:0]     cap_q;
  logic              act_q, pend_q;
  logic [PW-1:0]     pg [NTGT];

  for (genvar i = 0; i < NTGT; i++) begin : g_pg
    assign pg[i] = base_page[PW*i +: PW];
  end

  wire [1:0]    aidx   = sel_q[1:0];
  wire [3:0]    cap_en = sel_q[7:4];
  wire [PW-1:0] act_pg = pg[aidx];
  wire          roll   = roll_en[aidx];
  wire          hw_byte = byte_done & act_q;
  wire          do_cap  = hw_byte & pend_q & ~dir_rd;
  wire          wr_sel  = sw_wr && (sw_addr == 2'd0);
  wire          wr_cur  = sw_wr && (sw_addr == 2'd1);
  wire          wr_rd   = sw_wr && (sw_addr == 2'd2);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic r);
    if (a == {AW{1'b1}}) bump = r ? '0 : a;
    else                 bump = a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)             sel_q <= '0;
    else if (wr_sel)        sel_q <= sw_wdata[7:0];
    else if (match_evt)     sel_q[3:0] <= {2'b00, match_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (match_evt) begin
      act_q  <= 1'b1;
      pend_q <= cap_en[match_idx];
    end else if (bus_stop) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (hw_byte) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (do_cap) cap_q <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_q <= '0;
    else if (wr_cur)    cur_q <= sw_wdata[PW+AW-1:0];
    else if (match_evt) cur_q[PW+AW-1:AW] <= pg[match_idx];
    else if (do_cap)    cur_q <= {act_pg, rx_byte};
    else if (hw_byte)   cur_q[AW-1:0] <= bump(cur_q[AW-1:0], roll);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rd_q <= '0;
    else if (wr_rd)            rd_q <= (sw_wdata == 16'h0000) ? {act_pg, cap_q} : sw_wdata[PW+AW-1:0];
    else if (hw_byte && dir_rd) rd_q[AW-1:0] <= bump(rd_q[AW-1:0], roll);
  end

  always_comb begin
    case (sw_addr)
      2'd0:    sw_rdata = {8'h00, sel_q};
      2'd1:    sw_rdata = {5'b0, cur_q};
      2'd2:    sw_rdata = {5'b0, rd_q};
      default: sw_rdata = 16'h0000;
    endcase
  end

  assign tx_page = sel_q[3:0];
  assign mem_loc = cur_q;
endmodule

module tgt_ptr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        match_evt,
  input logic [1:0]  match_idx,
  input logic        bus_stop,
  input logic        byte_done,
  input logic [3:0]  roll_en,
  input logic        sw_wr,
  input logic [1:0]  sw_addr,
  input logic [15:0] sw_wdata,
  input logic [15:0] sw_rdata,
  input logic [3:0]  tx_page,
  input logic [10:0] mem_loc,
  input logic        act_q,
  input logic        pend_q
);
  AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !(sw_wr && sw_addr == 2'd0)) |=> tx_page == {2'b00, $past(match_idx)}); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[15:11] == 5'b0); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && act_q && !pend_q && !sw_wr && !match_evt && mem_loc[7:0] == 8'hFF && !roll_en[tx_page[1:0]])
    |=> mem_loc[7:0] == 8'hFF); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && act_q && !pend_q && !sw_wr && !match_evt && mem_loc[7:0] == 8'hFF && roll_en[tx_page[1:0]])
    |=> mem_loc[7:0] == 8'h00); // R6
  AST_SW_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == 2'd1) |=> mem_loc == $past(sw_wdata[10:0])); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !act_q && !sw_wr && !match_evt) |=> $stable(mem_loc)); // R10
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !match_evt) |=> !act_q); // R10
endmodule

bind tgt_ptr_unit tgt_ptr_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .match_idx(match_idx),
  .bus_stop(bus_stop), .byte_done(byte_done), .roll_en(roll_en),
  .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
  .tx_page(tx_page), .mem_loc(mem_loc), .act_q(act_q), .pend_q(pend_q)
);

// File: tb/tgt_ptr_unit_tb_top.sv
`timescale 1ns/100ps
module tgt_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        match_evt, bus_stop, byte_done, dir_rd, sw_wr;
  logic [1:0]  match_idx, sw_addr;
  logic [7:0]  rx_byte;
  logic [11:0] base_page;
  logic [3:0]  roll_en;
  logic [15:0] sw_wdata, sw_rdata;
  logic [3:0]  tx_page;
  logic [10:0] mem_loc;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0]  m_sel, m_cap;
  logic [10:0] m_cur, m_rd;
  logic        m_act, m_pend;

  always #2.5 clk = ~clk;

  tgt_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .match_idx(match_idx),
    .bus_stop(bus_stop), .byte_done(byte_done), .dir_rd(dir_rd), .rx_byte(rx_byte),
    .base_page(base_page), .roll_en(roll_en), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_page(tx_page), .mem_loc(mem_loc)
  );

  function automatic logic [7:0] nxt(input logic [7:0] a, input logic r);
    if (a == 8'hFF) return r ? 8'h00 : 8'hFF;
    return a + 8'd1;
  endfunction

  function automatic logic [2:0] bpg(input logic [1:0] i);
    return base_page[3*i +: 3];
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {8'h00, m_sel};
      2'd1:    return {5'b0, m_cur};
      2'd2:    return {5'b0, m_rd};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    logic [7:0]  s;
    logic [10:0] c, r;
    logic [7:0]  k;
    logic        a, p, hb, cp;
    s = m_sel; c = m_cur; r = m_rd; k = m_cap; a = m_act; p = m_pend;
    if (!rst_n) begin
      s = 0; c = 0; r = 0; k = 0; a = 0; p = 0;
    end else begin
      hb = byte_done && m_act;
      cp = hb && m_pend && !dir_rd;
      if (sw_wr && sw_addr == 2'd0) s = sw_wdata[7:0];
      else if (match_evt) s[3:0] = {2'b00, match_idx};
      if (match_evt) begin a = 1; p = m_sel[4 + match_idx]; end
      else if (bus_stop) begin a = 0; p = 0; end
      else if (hb) p = 0;
      if (cp) k = rx_byte;
      if (sw_wr && sw_addr == 2'd1) c = sw_wdata[10:0];
      else if (match_evt) c[10:8] = bpg(match_idx);
      else if (cp) c = {bpg(m_sel[1:0]), rx_byte};
      else if (hb) c[7:0] = nxt(m_cur[7:0], roll_en[m_sel[1:0]]);
      if (sw_wr && sw_addr == 2'd2) r = (sw_wdata == 16'h0) ? {bpg(m_sel[1:0]), m_cap} : sw_wdata[10:0];
      else if (hb && dir_rd) r[7:0] = nxt(m_rd[7:0], roll_en[m_sel[1:0]]);
    end
    m_sel = s; m_cur = c; m_rd = r; m_cap = k; m_act = a; m_pend = p;
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "tx_page", {12'h0, tx_page}, {12'h0, m_sel[3:0]});
    chk(tag, "mem_loc", {5'h0, mem_loc}, {5'h0, m_cur});
    chk(tag, "sw_rdata", sw_rdata, exp_rdata(sw_addr));
  endtask

  task automatic idle();
    match_evt = 0; bus_stop = 0; byte_done = 0; sw_wr = 0; dir_rd = 0;
  endtask

  task automatic swr(input logic [1:0] a, input logic [15:0] d, input string tag);
    idle(); sw_wr = 1; sw_addr = a; sw_wdata = d; tick(tag); sw_wr = 0;
  endtask

  task automatic mtch(input logic [1:0] i, input string tag);
    idle(); match_evt = 1; match_idx = i; tick(tag); match_evt = 0;
  endtask

  task automatic byt(input logic rd, input logic [7:0] b, input string tag);
    idle(); byte_done = 1; dir_rd = rd; rx_byte = b; tick(tag); byte_done = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0; match_idx = 0; rx_byte = 0; sw_addr = 0; sw_wdata = 0;
    base_page = {3'd7, 3'd5, 3'd3, 3'd1};
    roll_en = 4'b0000;
    m_sel = 8'hA5; m_cur = 0; m_rd = 0; m_cap = 0; m_act = 0; m_pend = 0;
    tick("R1"); tick("R1");
    sw_addr = 2'd1; tick("R1");
    sw_addr = 2'd2; tick("R1");
    rst_n = 1;
    swr(2'd0, 16'h0003, "R4");
    chk("R4", "tx_page literal", {12'h0, tx_page}, 16'h0003);
    byt(0, 8'h11, "R10");
    chk("R10", "mem_loc literal", {5'h0, mem_loc}, 16'h0000);
    mtch(2'd2, "R2");
    chk("R2", "tx_page literal", {12'h0, tx_page}, 16'h0002);
    chk("R2", "page literal", {13'h0, mem_loc[10:8]}, 16'h0005);
    swr(2'd1, 16'h05FE, "R6");
    byt(0, 8'h00, "R6");
    byt(0, 8'h00, "R6");
    chk("R6", "saturate literal", {5'h0, mem_loc}, 16'h05FF);
    roll_en = 4'b0100;
    byt(1, 8'h00, "R6");
    chk("R6", "wrap literal", {5'h0, mem_loc}, 16'h0500);
    swr(2'd0, 16'h0020, "R3");
    mtch(2'd1, "R3");
    byt(0, 8'h3C, "R3");
    chk("R3", "capture literal", {5'h0, mem_loc}, 16'h033C);
    byt(0, 8'h99, "R3");
    chk("R3", "after capture literal", {5'h0, mem_loc}, 16'h033D);
    swr(2'd2, 16'h0000, "R8");
    chk("R8", "reload literal", sw_rdata, 16'h033C);
    swr(2'd2, 16'h0123, "R8");
    byt(1, 8'h00, "R7");
    sw_addr = 2'd2; tick("R7");
    chk("R7", "read ptr literal", sw_rdata, 16'h0124);
    idle(); sw_wr = 1; sw_addr = 2'd1; sw_wdata = 16'h0610; byte_done = 1; dir_rd = 1;
    tick("R9");
    chk("R9", "sw over hw literal", {5'h0, mem_loc}, 16'h0610);
    idle(); bus_stop = 1; tick("R10");
    byt(1, 8'h00, "R10");
    chk("R10", "after stop literal", {5'h0, mem_loc}, 16'h0610);
    swr(2'd1, 16'hFFFF, "R5");
    chk("R5", "masked literal", sw_rdata, 16'h07FF);
    sw_addr = 2'd3; tick("R5");
    for (int i = 0; i < 4000; i++) begin
      int sel;
      idle();
      sel = int'($urandom_range(0, 99));
      if (sel < 10) begin match_evt = 1; match_idx = 2'($urandom_range(0, 3)); end
      else if (sel < 14) bus_stop = 1;
      byte_done = ($urandom_range(0, 99) < 45);
      dir_rd = 1'($urandom_range(0, 1));
      rx_byte = 8'($urandom);
      sw_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 8) begin
        sw_wr = 1;
        sw_wdata = 16'($urandom);
        if ($urandom_range(0, 3) == 0) sw_wdata = 16'h0000;
        else if (sw_addr != 2'd0) sw_wdata[7:0] = 8'(8'hFC + $urandom_range(0, 3));
      end
      if ($urandom_range(0, 49) == 0) roll_en = 4'($urandom);
      if ($urandom_range(0, 99) == 0) base_page = 12'($urandom);
      tick("R2 R3 R6 R7 R8 R9 R10");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule